// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block runs the command dialogue that erases a parallel NOR-flash array over an asynchronous word bus. A host pulses a request with an operation code (0 = whole-array erase, 1 = single-sector erase, 2 = suspend, 3 = resume), a sector base address and an unlock-bypass flag. The sequencer then walks a fixed list of command writes. A reset command comes first. Unlock pairs come next, unless bypass is set. Then come the erase-setup command and the final erase command. After that it polls the array status word until the erase is judged finished, and reports a one-cycle done pulse with a pass/fail result.

The bus is one 32-bit word made of two 16-bit lanes, one for each of two x16 devices sitting side by side. Every command byte goes out in the low byte of each lane. A sector erase can be parked during polling so that other sectors can be read. Parking writes the suspend command to the sector and then a reset. A later resume request restarts it, and polling continues until the erase completes.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, busy_o, done_o, pass_o, suspended_o, bus_we_o and bus_re_o are all 0.
- R2: A whole-array erase (op 0, bypass 0) issues these writes in order: F0 to 0x555, AA to 0x555, 55 to 0x2AA, 80 to 0x555, AA to 0x555, 55 to 0x2AA, 10 to 0x555. It then issues status reads at word address 0.
- R3: A sector erase (op 1) follows the R2 order but ends with 30 written to sector+0x555. Its status reads also go to sector+0x555.
- R4: With the bypass flag set at request time, both unlock pairs are left out, so the writes are F0, 80 and the final erase command.
- R5: Each write word carries the command byte in bits 7:0 of every 16-bit lane, with bits 15:8 of each lane zero (80 becomes 0x00800080).
- R6: A strobe (bus_we_o or bus_re_o, never both) stays high with stable address and data until the cycle in which bus_ack_i is 1. It drops on the next cycle. Read data is taken in the ack cycle.
- R7: Polling ends with pass when bit 7 reads 1 in every lane. A status word with bit 7 set in only one lane keeps polling.
- R8: When bit 5 is 1 in every lane while R7 is not met, exactly one more status read follows. The result is pass if that read meets R7, and fail otherwise.
- R9: A suspend request during a sector erase takes effect after the current status read. The block writes B0 to the sector base address, then F0 to 0x555, and signals done with pass. suspended_o then goes to 1 and busy_o to 0.
- R10: A resume request in the suspended state writes F0 to 0x555, then 30 to the sector base latched at erase start (the address input is not used). Polling then resumes at sector+0x555 as in R7/R8, and suspended_o clears.
- R11: Requests are ignored and cause no bus access in these cases: any request other than a suspend during a sector erase while busy, a suspend during a whole-array erase, anything but a resume while suspended, and a suspend or resume while idle.
- R12: done_o is high for exactly one cycle per operation. pass_o changes only together with done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, sampled each cycle |
| op_i | input | 2 | Operation: 0 array, 1 sector, 2 suspend, 3 resume |
| sect_addr_i | input | ADDR_W | Sector base word address |
| bypass_i | input | 1 | Unlock-bypass mode active |
| busy_o | output | 1 | Operation running |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Result of last completed operation |
| suspended_o | output | 1 | Sector erase parked |
| bus_addr_o | output | ADDR_W | Bus word address |
| bus_wdata_o | output | LANES*LANE_W | Bus write data |
| bus_we_o | output | 1 | Write strobe |
| bus_re_o | output | 1 | Read strobe |
| bus_ack_i | input | 1 | Access completes this cycle |
| bus_rdata_i | input | LANES*LANE_W | Bus read data |

## Verification
The bench builds the block with its defaults: a 24-bit word address, two 16-bit lanes, status bits 7 and 5, and command and unlock offsets 0x555 and 0x2AA. Two lanes are what make the per-lane corners reachable: a status word with bit 7 set in one lane only, and replication of each command byte into both lanes. The responder adds zero to two wait cycles per access, which exercises the strobe hold under different ack latencies.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam int STEP_W = 3;

  typedef enum logic [1:0] {OP_CHIP = 2'd0, OP_SECTOR = 2'd1, OP_SUSPEND = 2'd2, OP_RESUME = 2'd3} op_e;
  typedef enum logic [1:0] {K_SKIP, K_WR, K_POLL, K_END} kind_e;
  typedef enum logic [2:0] {A_CMD, A_UNLK, A_SECT, A_SECT_CMD, A_BASE} asel_e;
  typedef enum logic [1:0] {S_IDLE, S_STEP, S_ACC, S_SUSP} fsm_e;

  typedef struct packed {
    kind_e      kind;
    asel_e      asel;
    logic [7:0] cmd;
  } step_t;

  localparam logic [7:0] CMD_RESET = 8'hF0;
  localparam logic [7:0] CMD_UNLK1 = 8'hAA;
  localparam logic [7:0] CMD_UNLK2 = 8'h55;
  localparam logic [7:0] CMD_SETUP = 8'h80;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_SUSP  = 8'hB0;
endpackage

// File: rtl/fes_step_table.sv
module fes_step_table
  import flash_erase_pkg::*;
(
  input  op_e               op_i,
  input  logic              bypass_i,
  input  logic [STEP_W-1:0] step_i,
  output step_t             step_o
);
  kind_e unlk_kind;
  assign unlk_kind = bypass_i ? K_SKIP : K_WR;

  always_comb begin
    step_o = '{K_END, A_CMD, 8'h00};
    case (op_i)
      OP_CHIP, OP_SECTOR: begin
        case (step_i)
          3'd0: step_o = '{K_WR, A_CMD, CMD_RESET};
          3'd1, 3'd4: step_o = '{unlk_kind, A_CMD, CMD_UNLK1};
          3'd2, 3'd5: step_o = '{unlk_kind, A_UNLK, CMD_UNLK2};
          3'd3: step_o = '{K_WR, A_CMD, CMD_SETUP};
          3'd6: step_o = (op_i == OP_CHIP) ? '{K_WR, A_CMD, CMD_CHIP}
                                           : '{K_WR, A_SECT_CMD, CMD_SECT};
          default: step_o = (op_i == OP_CHIP) ? '{K_POLL, A_BASE, 8'h00}
                                              : '{K_POLL, A_SECT_CMD, 8'h00};
        endcase
      end
      OP_SUSPEND: begin
        case (step_i)
          3'd0: step_o = '{K_WR, A_SECT, CMD_SUSP};
          3'd1: step_o = '{K_WR, A_CMD, CMD_RESET};
          default: step_o = '{K_END, A_CMD, 8'h00};
        endcase
      end
      default: begin
        case (step_i)
          3'd0: step_o = '{K_WR, A_CMD, CMD_RESET};
          3'd1: step_o = '{K_WR, A_SECT, CMD_SECT};
          default: step_o = '{K_POLL, A_SECT_CMD, 8'h00};
        endcase
      end
    endcase
  end
endmodule

// File: rtl/fes_lane_pack.sv
module fes_lane_pack #(
  parameter int LANES  = 2,
  parameter int LANE_W = 16
) (
  input  logic [7:0]              cmd_i,
  output logic [LANES*LANE_W-1:0] data_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign data_o[l*LANE_W +: LANE_W] = {{(LANE_W-8){1'b0}}, cmd_i};
  end
endmodule

// File: rtl/fes_status_eval.sv
module fes_status_eval #(
  parameter int LANES    = 2,
  parameter int LANE_W   = 16,
  parameter int DONE_BIT = 7,
  parameter int TOUT_BIT = 5
) (
  input  logic [LANES*LANE_W-1:0] data_i,
  output logic                    all_done_o,
  output logic                    all_tout_o
);
  logic [LANES-1:0] done_v, tout_v;
  logic unused_data;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign done_v[l] = data_i[l*LANE_W + DONE_BIT];
    assign tout_v[l] = data_i[l*LANE_W + TOUT_BIT];
  end

  assign all_done_o  = &done_v;
  assign all_tout_o  = &tout_v;
  assign unused_data = ^data_i;
endmodule

// File: rtl/fes_bus_port.sv
module fes_bus_port #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              fin_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_we_o,
  output logic              bus_re_o,
  input  logic              bus_ack_i
);
  logic active;
  assign active = bus_we_o | bus_re_o;
  assign fin_o  = active & bus_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
      bus_we_o    <= 1'b0;
      bus_re_o    <= 1'b0;
    end else if (fin_o) begin
      bus_we_o <= 1'b0;
      bus_re_o <= 1'b0;
    end else if (start_i && !active) begin
      bus_addr_o  <= addr_i;
      bus_wdata_o <= write_i ? wdata_i : '0;
      bus_we_o    <= write_i;
      bus_re_o    <= !write_i;
    end
  end

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !bus_ack_i) |=> (active && $stable(bus_addr_o) && $stable(bus_wdata_o)
                                && $stable(bus_we_o)));
  assert_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> !active);
  assert_start_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int              ADDR_W   = 24,
  parameter int              LANES    = 2,
  parameter int              LANE_W   = 16,
  parameter int              DONE_BIT = 7,
  parameter int              TOUT_BIT = 5,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 'h555,
  parameter logic [ADDR_W-1:0] UNLK_OFS = 'h2AA,
  localparam int             DATA_W   = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] sect_addr_i,
  input  logic              bypass_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              suspended_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_we_o,
  output logic              bus_re_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  fsm_e              state_q;
  op_e               op_q, req_op;
  logic [ADDR_W-1:0] sect_q, acc_addr;
  logic              bypass_q, recheck_q, susp_pend_q;
  logic [STEP_W-1:0] step_q;
  step_t             st;
  logic [DATA_W-1:0] cmd_word;
  logic              start, bus_fin, all_done, all_tout, susp_ok, erase_req;

  assign req_op = op_e'(op_i);

  fes_step_table u_table (
    .op_i(op_q), .bypass_i(bypass_q), .step_i(step_q), .step_o(st)
  );

  fes_lane_pack #(.LANES(LANES), .LANE_W(LANE_W)) u_pack (
    .cmd_i(st.cmd), .data_o(cmd_word)
  );

  fes_status_eval #(.LANES(LANES), .LANE_W(LANE_W), .DONE_BIT(DONE_BIT), .TOUT_BIT(TOUT_BIT)) u_eval (
    .data_i(bus_rdata_i), .all_done_o(all_done), .all_tout_o(all_tout)
  );

  always_comb begin
    case (st.asel)
      A_CMD:      acc_addr = CMD_OFS;
      A_UNLK:     acc_addr = UNLK_OFS;
      A_SECT:     acc_addr = sect_q;
      A_SECT_CMD: acc_addr = sect_q + CMD_OFS;
      default:    acc_addr = '0;
    endcase
  end

  assign start = (state_q == S_STEP) && (st.kind == K_WR || st.kind == K_POLL);

  fes_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .write_i(st.kind == K_WR),
    .addr_i(acc_addr), .wdata_i(cmd_word), .fin_o(bus_fin),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
    .bus_we_o(bus_we_o), .bus_re_o(bus_re_o), .bus_ack_i(bus_ack_i)
  );

  assign busy_o      = (state_q == S_STEP) || (state_q == S_ACC);
  assign suspended_o = (state_q == S_SUSP);
  assign erase_req   = req_i && (req_op == OP_CHIP || req_op == OP_SECTOR);
  // only a sector erase (fresh or resumed) may be parked
  assign susp_ok     = req_i && (req_op == OP_SUSPEND) && busy_o &&
                       (op_q == OP_SECTOR || op_q == OP_RESUME);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      op_q        <= OP_CHIP;
      sect_q      <= '0;
      bypass_q    <= 1'b0;
      step_q      <= '0;
      recheck_q   <= 1'b0;
      susp_pend_q <= 1'b0;
      done_o      <= 1'b0;
      pass_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (susp_ok) susp_pend_q <= 1'b1;
      case (state_q)
        S_IDLE: if (erase_req) begin
          op_q        <= req_op;
          sect_q      <= sect_addr_i;
          bypass_q    <= bypass_i;
          step_q      <= '0;
          recheck_q   <= 1'b0;
          susp_pend_q <= 1'b0;
          state_q     <= S_STEP;
        end
        S_SUSP: if (req_i && req_op == OP_RESUME) begin
          op_q        <= OP_RESUME;
          step_q      <= '0;
          recheck_q   <= 1'b0;
          susp_pend_q <= 1'b0;
          state_q     <= S_STEP;
        end
        S_STEP: begin
          case (st.kind)
            K_SKIP: step_q <= step_q + 1'b1;
            K_END: begin
              done_o  <= 1'b1;
              pass_o  <= 1'b1;
              state_q <= (op_q == OP_SUSPEND) ? S_SUSP : S_IDLE;
            end
            default: state_q <= S_ACC;
          endcase
        end
        default: if (bus_fin) begin
          state_q <= S_STEP;
          if (st.kind == K_WR) begin
            step_q <= step_q + 1'b1;
          end else if (recheck_q || all_done) begin
            done_o  <= 1'b1;
            pass_o  <= all_done;
            state_q <= S_IDLE;
          end else if (all_tout) begin
            recheck_q <= 1'b1;
          end else if (susp_pend_q) begin
            op_q        <= OP_SUSPEND;
            step_q      <= '0;
            susp_pend_q <= 1'b0;
          end
        end
      endcase
    end
  end

  assert_busy_susp_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && suspended_o));
  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_pass_with_done_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pass_o) |-> done_o);
  assert_quiet_when_parked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE || state_q == S_SUSP) |-> !(bus_we_o || bus_re_o));
  assert_upper_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |-> (bus_wdata_o[LANE_W-1:8] == '0));
  for (genvar l = 1; l < LANES; l++) begin : g_dup
    assert_lane_dup_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_we_o |-> (bus_wdata_o[l*LANE_W +: LANE_W] == bus_wdata_o[LANE_W-1:0]));
  end
endmodule

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [23:0] sect = '0;
  logic        byp = 1'b0;
  logic        busy, done, pass, susp, bwe, bre;
  logic [23:0] baddr;
  logic [31:0] bwdata;
  logic        back = 1'b0;
  logic [31:0] brdata = '0;

  int nchecks = 0, nerr = 0;
  int log_n = 0, rd_idx = 0, rd_base = 0, done_cnt = 0, cur = 0;
  logic        log_we [256];
  logic [23:0] log_addr [256];
  logic [31:0] log_data [256];
  logic [31:0] stat_q [16];
  logic [31:0] stat_fill = '0;
  int wcnt = 0;
  logic prev_done = 1'b0;

  localparam logic [23:0] SECT = 24'h040000;

  always #10 clk = ~clk;

  flash_erase_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .sect_addr_i(sect),
    .bypass_i(byp), .busy_o(busy), .done_o(done), .pass_o(pass), .suspended_o(susp),
    .bus_addr_o(baddr), .bus_wdata_o(bwdata), .bus_we_o(bwe), .bus_re_o(bre),
    .bus_ack_i(back), .bus_rdata_i(brdata)
  );

  // responder: 0..2 wait cycles, logs each access, serves status words
  always @(posedge clk) begin
    if (!rst_n) begin
      back <= 1'b0;
      wcnt <= 0;
    end else if ((bwe || bre) && !back) begin
      if (wcnt >= (log_n % 3)) begin
        back <= 1'b1;
        wcnt <= 0;
        log_we[log_n % 256]   <= bwe;
        log_addr[log_n % 256] <= baddr;
        log_data[log_n % 256] <= bwdata;
        log_n <= log_n + 1;
        if (bre) begin
          brdata <= (rd_idx - rd_base < 16) ? stat_q[rd_idx - rd_base] : stat_fill;
          rd_idx <= rd_idx + 1;
        end
      end else wcnt <= wcnt + 1;
    end else back <= 1'b0;
  end

  always @(negedge clk) begin
    if (done) begin
      done_cnt <= done_cnt + 1;
      if (prev_done) begin
        nchecks++; nerr++;
        $display("FAIL R12: done high two cycles, actual 1 expected 0");
      end
    end
    prev_done <= done;
  end

  function automatic logic [31:0] rep(input logic [7:0] b);
    return {8'h00, b, 8'h00, b};
  endfunction

  task automatic check(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic entry(input logic we, input logic [23:0] a, input logic [31:0] d, input string r);
    int i = cur % 256;
    check(log_we[i] == we && log_addr[i] == a && (!we || log_data[i] == d), r,
          {7'd0, log_we[i], log_addr[i], log_data[i]}, {7'd0, we, a, we ? d : log_data[i]});
    cur++;
  endtask

  task automatic ew(input logic [23:0] a, input logic [7:0] b, input string r);
    entry(1'b1, a, rep(b), r);
  endtask

  task automatic er(input logic [23:0] a, input string r);
    entry(1'b0, a, '0, r);
  endtask

  task automatic setup_stat(input logic [31:0] s0, input logic [31:0] s1, input logic [31:0] s2,
                            input logic [31:0] fill);
    for (int k = 0; k < 16; k++) stat_q[k] = fill;
    stat_q[0] = s0; stat_q[1] = s1; stat_q[2] = s2;
    stat_fill = fill;
    rd_base = rd_idx;
    cur = log_n;
  endtask

  task automatic pulse(input logic [1:0] o, input logic [23:0] s, input logic b);
    @(negedge clk);
    req = 1'b1; op = o; sect = s; byp = b;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_done(input string r);
    int start = done_cnt;
    bit seen = 0;
    for (int k = 0; k < 3000; k++) begin
      @(posedge clk);
      if (done_cnt > start) begin seen = 1; break; end
    end
    check(seen, r, 64'(done_cnt), 64'(start + 1));
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check(!busy && !done && !pass && !susp && !bwe && !bre, "R1",
          {59'd0, busy, done, pass, susp, bwe | bre}, 64'd0);
  endtask

  task automatic t_chip();
    int base;
    setup_stat(32'h0, 32'h0, 32'h00800080, 32'h00800080);
    base = log_n;
    pulse(2'd0, SECT, 1'b0);
    repeat (3) @(negedge clk);
    pulse(2'd1, 24'h100000, 1'b1);  // R11: erase while busy ignored
    pulse(2'd2, SECT, 1'b0);        // R11: suspend of array erase ignored
    wait_done("R7 array erase done");
    ew(24'h555, 8'hF0, "R2 reset"); ew(24'h555, 8'hAA, "R2 unlock1");
    ew(24'h2AA, 8'h55, "R2 unlock2"); ew(24'h555, 8'h80, "R2 setup");
    ew(24'h555, 8'hAA, "R2 unlock1b"); ew(24'h2AA, 8'h55, "R2 unlock2b");
    ew(24'h555, 8'h10, "R2 array cmd R5");
    er(24'h0, "R2 poll0"); er(24'h0, "R2 poll1"); er(24'h0, "R2 poll2");
    check(log_n - base == 10, "R11 no extra access in array erase", 64'(log_n - base), 64'd10);
    check(pass && !busy, "R7 pass", {62'd0, pass, busy}, 64'd2);
  endtask

  task automatic t_sector_full();
    setup_stat(32'h00000080, 32'h00800080, 32'h0, 32'h0);
    pulse(2'd1, SECT, 1'b0);
    wait_done("R3 sector done");
    ew(24'h555, 8'hF0, "R3 reset"); ew(24'h555, 8'hAA, "R3 unlock1");
    ew(24'h2AA, 8'h55, "R3 unlock2"); ew(24'h555, 8'h80, "R3 setup");
    ew(24'h555, 8'hAA, "R3 unlock1b"); ew(24'h2AA, 8'h55, "R3 unlock2b");
    ew(SECT + 24'h555, 8'h30, "R3 sector cmd");
    er(SECT + 24'h555, "R7 one-lane bit7 keeps polling"); er(SECT + 24'h555, "R3 poll");
    check(log_n == cur, "R7 read count", 64'(log_n), 64'(cur));
    check(pass, "R7 pass", 64'(pass), 64'd1);
  endtask

  task automatic t_bypass();
    setup_stat(32'h00800080, 32'h0, 32'h0, 32'h0);
    pulse(2'd1, SECT, 1'b1);
    wait_done("R4 done");
    ew(24'h555, 8'hF0, "R4 reset"); ew(24'h555, 8'h80, "R4 setup");
    ew(SECT + 24'h555, 8'h30, "R4 final"); er(SECT + 24'h555, "R4 poll");
    check(log_n == cur, "R4 count", 64'(log_n), 64'(cur));
  endtask

  task automatic t_timeout(input logic [31:0] second, input bit exp_pass, input string r);
    setup_stat(32'h00200020, second, 32'h0, 32'h00800080);
    pulse(2'd1, SECT, 1'b1);
    wait_done(r);
    cur = cur + 3;
    er(SECT + 24'h555, r); er(SECT + 24'h555, r);
    check(log_n == cur, {r, " single recheck"}, 64'(log_n), 64'(cur));
    check(pass == exp_pass, {r, " result"}, 64'(pass), 64'(exp_pass));
  endtask

  task automatic t_suspend_resume();
    int n, base;
    bit seen = 0;
    setup_stat(32'h0, 32'h0, 32'h0, 32'h0);
    base = log_n;
    pulse(2'd1, SECT, 1'b1);
    for (int k = 0; k < 500; k++) begin
      @(posedge clk);
      if (rd_idx - rd_base >= 2) begin seen = 1; break; end
    end
    check(seen, "R9 polling started", 64'(rd_idx - rd_base), 64'd2);
    pulse(2'd2, 24'h7F0000, 1'b0);
    wait_done("R9 suspend done");
    n = log_n - base;
    ew(24'h555, 8'hF0, "R9 reset"); ew(24'h555, 8'h80, "R9 setup");
    ew(SECT + 24'h555, 8'h30, "R9 final");
    for (int k = 3; k < n - 2; k++) er(SECT + 24'h555, "R9 poll before park");
    ew(SECT, 8'hB0, "R9 suspend cmd"); ew(24'h555, 8'hF0, "R9 reset after suspend");
    check(pass && susp && !busy, "R9 parked", {61'd0, pass, susp, busy}, 64'd6);
    base = log_n;
    pulse(2'd0, SECT, 1'b0);
    pulse(2'd1, SECT, 1'b0);
    pulse(2'd2, SECT, 1'b0);
    repeat (30) @(negedge clk);
    check(log_n == base && susp && !busy, "R11 parked ignores non-resume",
          64'(log_n - base), 64'd0);
    setup_stat(32'h0, 32'h00800080, 32'h0, 32'h0);
    pulse(2'd3, 24'h7F0000, 1'b0);
    wait_done("R10 resume done");
    ew(24'h555, 8'hF0, "R10 reset"); ew(SECT, 8'h30, "R10 resume cmd latched sector");
    er(SECT + 24'h555, "R10 poll"); er(SECT + 24'h555, "R10 poll");
    check(log_n == cur, "R10 count", 64'(log_n), 64'(cur));
    check(pass && !susp && !busy, "R10 finished", {61'd0, pass, susp, busy}, 64'd4);
  endtask

  task automatic t_idle_ignore();
    int base = log_n;
    pulse(2'd2, SECT, 1'b0);
    pulse(2'd3, SECT, 1'b0);
    repeat (30) @(negedge clk);
    check(log_n == base && !busy && !susp, "R11 idle ignores suspend/resume",
          64'(log_n - base), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchecks++; nerr++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_chip();
    t_sector_full();
    t_bypass();
    t_timeout(32'h00800080, 1'b1, "R8 recheck pass");
    t_timeout(32'h00200020, 1'b0, "R8 recheck fail");
    t_suspend_resume();
    t_idle_ignore();
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule